// File: doc/BRIEF.md
# Speculative Reorder Buffer with Store Ordering

This block keeps the results of instructions that finish in any order and retires them strictly in issue order. An issue stage allocates one entry per instruction at the tail. Each entry is a register operation, a store, or a branch. Execution units later report completion by entry number. That report carries a result value, an exception flag and a mispredict flag. Only the oldest entry may retire, and only once it is complete. A register operation then drives a register-file write strobe, a store drives a memory write strobe, and a branch drives neither.

Between completion and retirement, the issue stage can look up an architectural register. The lookup returns whether a write to that register is still pending, which entry holds the newest such write, and that entry's value once it is ready. Some events only take effect when their entry reaches the head: a mispredicted branch, and an instruction that raised an exception. Such an event empties the whole buffer. An excepting instruction writes nothing and is signalled with its entry number. A load-hazard query tells the issue stage whether any store still held in the buffer targets a given address. A load allocated after that query is younger than every store in the buffer.

The allocate port is valid/ready. A transfer happens on a clock edge where both `alloc_valid` and `alloc_ready` are high. While `alloc_ready` is low, the issue stage holds its payload steady. `alloc_ready` drops when all entries are held, and during a cycle in which the head flushes the buffer. The completion port has no ready, so every completion is accepted. The commit strobes are one-cycle pulses that the register file and memory must take.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, no commit strobe, flush or exception is active, `lk_busy` is 0 and `ld_conflict` is 0.
- R2: Entries are handed out at the tail in issue order. `alloc_tag` starts at 0 and advances by one, modulo 8, per accepted allocation. With 8 entries held, `alloc_ready` is 0.
- R3: The head entry retires in the cycle after it is complete, and at most one entry retires per cycle. `alloc_kind` is 0 for a register operation, 1 for a store and 2 for a branch. A register operation pulses `rf_we` with its register and value. A store pulses `mem_we` with its address and value. A branch that was not mispredicted retires with no strobe.
- R4: An entry that completes before an older entry does not retire until every older entry has retired. Register writes leave the block in allocation order.
- R5: `lk_busy` is 1 while a register operation writing `lk_reg` is held. `lk_tag` names the newest such entry. `lk_ready` and `lk_value` show its completion state and result.
- R6: A mispredicted branch reaching the head pulses `flush_out` and discards every younger entry without writing. The next allocation receives the entry number after the branch.
- R7: An instruction completed with `cmp_exc` = 1 writes nothing when it reaches the head. It pulses `exc_out` with `exc_tag` equal to its entry number, pulses `flush_out`, and empties the buffer. The next allocation receives the entry number after it.
- R8: When an entry retires, its register stays busy in the lookup if a newer pending writer of that register exists. The newer entry's tag is kept.
- R9: `ld_conflict` is 1 exactly when some held store has an address equal to `ld_addr`. A store stops conflicting once it has retired.
- R10: After a flush, no register reads as busy in the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Entry free and no flush this cycle |
| alloc_kind | input | 2 | 0 register op, 1 store, 2 branch |
| alloc_reg | input | 5 | Destination register of a register op |
| alloc_addr | input | 16 | Memory address of a store |
| alloc_tag | output | 3 | Entry number given to this allocation |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | 3 | Entry that completed |
| cmp_value | input | 32 | Result (store data for a store) |
| cmp_exc | input | 1 | Instruction raised an exception |
| cmp_mispred | input | 1 | Branch was mispredicted |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 5 | Register written |
| rf_data | output | 32 | Register write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 32 | Memory write data |
| flush_out | output | 1 | Buffer emptied this cycle |
| exc_out | output | 1 | Precise exception at head |
| exc_tag | output | 3 | Entry number of excepting instruction |
| lk_reg | input | 5 | Register to look up |
| lk_busy | output | 1 | A held entry will write this register |
| lk_tag | output | 3 | Newest pending writer |
| lk_ready | output | 1 | That writer has completed |
| lk_value | output | 32 | That writer's result |
| ld_addr | input | 16 | Load address to check |
| ld_conflict | output | 1 | A held store targets this address |

## Verification
On every cycle, the assertions check several invariants. The occupancy never exceeds the entry count. A register write and a memory write never retire together. An exception never retires with a write. A flush leaves the buffer empty and the lookup clear. Retiring an older writer never drops the busy mark of a newer one. Only the directed scenarios can show the rest. These are in-order retirement after out-of-order completion, the exact values and addresses written, the tag sequence around a full buffer and after flushes, and the load-conflict answer before and after a store retires.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_regmap.sv
module rob_regmap #(
  parameter int NREG  = 32,
  parameter int TAG_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic [$clog2(NREG)-1:0]  set_reg,
  input  logic [TAG_W-1:0]         set_tag,
  input  logic                     clr_en,
  input  logic [$clog2(NREG)-1:0]  clr_reg,
  input  logic [TAG_W-1:0]         clr_tag,
  input  logic                     flush_all,
  input  logic [$clog2(NREG)-1:0]  lk_reg,
  output logic                     lk_busy,
  output logic [TAG_W-1:0]         lk_tag
);
  localparam int REG_W = $clog2(NREG);

  logic [NREG-1:0]  busy;
  logic [TAG_W-1:0] owner [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n || flush_all) begin
        busy[g] <= 1'b0;
      end else if (set_en && set_reg == REG_W'(g)) begin
        busy[g]  <= 1'b1;
        owner[g] <= set_tag;
      end else if (clr_en && clr_reg == REG_W'(g) && owner[g] == clr_tag) begin
        busy[g] <= 1'b0;
      end
    end
  end

  assign lk_busy = busy[lk_reg];
  assign lk_tag  = owner[lk_reg];

  // R10: a flush leaves no register marked busy
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (busy == '0));

  // R8: retiring an older writer keeps a newer writer's mark
  assert_keep_newer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && !flush_all && busy[clr_reg] && owner[clr_reg] != clr_tag)
      |=> busy[$past(clr_reg)]);
endmodule

// File: rtl/rob_ldhaz.sv
module rob_ldhaz #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16
) (
  input  logic [DEPTH-1:0]        cand,
  input  logic [DEPTH*ADDR_W-1:0] addr_flat,
  input  logic [ADDR_W-1:0]       ld_addr,
  output logic                    hit
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = cand[i] && (addr_flat[i*ADDR_W +: ADDR_W] == ld_addr);
  end

  assign hit = |match;
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREG   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [1:0]                alloc_kind,
  input  logic [$clog2(NREG)-1:0]   alloc_reg,
  input  logic [ADDR_W-1:0]         alloc_addr,
  output logic [$clog2(DEPTH)-1:0]  alloc_tag,
  input  logic                      cmp_valid,
  input  logic [$clog2(DEPTH)-1:0]  cmp_tag,
  input  logic [DATA_W-1:0]         cmp_value,
  input  logic                      cmp_exc,
  input  logic                      cmp_mispred,
  output logic                      rf_we,
  output logic [$clog2(NREG)-1:0]   rf_idx,
  output logic [DATA_W-1:0]         rf_data,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_data,
  output logic                      flush_out,
  output logic                      exc_out,
  output logic [$clog2(DEPTH)-1:0]  exc_tag,
  input  logic [$clog2(NREG)-1:0]   lk_reg,
  output logic                      lk_busy,
  output logic [$clog2(DEPTH)-1:0]  lk_tag,
  output logic                      lk_ready,
  output logic [DATA_W-1:0]         lk_value,
  input  logic [ADDR_W-1:0]         ld_addr,
  output logic                      ld_conflict
);
  localparam int TAG_W = $clog2(DEPTH);
  localparam int REG_W = $clog2(NREG);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  vld, rdy, exc, mis;
  kind_e             kind_q [DEPTH];
  logic [REG_W-1:0]  reg_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;

  function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic head_go, flush_now, alloc_fire;
  assign head_go     = vld[head] && rdy[head];
  assign flush_now   = head_go && (exc[head] || (kind_q[head] == K_BRANCH && mis[head]));
  assign alloc_ready = (count != CNT_W'(DEPTH)) && !flush_now;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  assign rf_we     = head_go && !exc[head] && kind_q[head] == K_REG;
  assign rf_idx    = reg_q[head];
  assign rf_data   = val_q[head];
  assign mem_we    = head_go && !exc[head] && kind_q[head] == K_STORE;
  assign mem_addr  = addr_q[head];
  assign mem_data  = val_q[head];
  assign exc_out   = head_go && exc[head];
  assign exc_tag   = head;
  assign flush_out = flush_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      rdy   <= '0;
      exc   <= '0;
      mis   <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (cmp_valid) begin
        rdy[cmp_tag]   <= 1'b1;
        val_q[cmp_tag] <= cmp_value;
        exc[cmp_tag]   <= cmp_exc;
        mis[cmp_tag]   <= cmp_mispred;
      end
      if (alloc_fire) begin
        vld[tail]    <= 1'b1;
        rdy[tail]    <= 1'b0;
        exc[tail]    <= 1'b0;
        mis[tail]    <= 1'b0;
        kind_q[tail] <= kind_e'(alloc_kind);
        reg_q[tail]  <= alloc_reg;
        addr_q[tail] <= alloc_addr;
        tail         <= nxt(tail);
      end
      if (flush_now) begin
        vld   <= '0;
        head  <= nxt(head);
        tail  <= nxt(head);
        count <= '0;
      end else begin
        if (head_go) begin
          vld[head] <= 1'b0;
          head      <= nxt(head);
        end
        count <= count + CNT_W'(alloc_fire) - CNT_W'(head_go);
      end
    end
  end

  rob_regmap #(.NREG(NREG), .TAG_W(TAG_W)) u_regmap (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (alloc_fire && kind_e'(alloc_kind) == K_REG),
    .set_reg   (alloc_reg),
    .set_tag   (tail),
    .clr_en    (head_go && kind_q[head] == K_REG),
    .clr_reg   (reg_q[head]),
    .clr_tag   (head),
    .flush_all (flush_now),
    .lk_reg    (lk_reg),
    .lk_busy   (lk_busy),
    .lk_tag    (lk_tag)
  );

  assign lk_ready = lk_busy && rdy[lk_tag];
  assign lk_value = val_q[lk_tag];

  logic [DEPTH-1:0]        st_cand;
  logic [DEPTH*ADDR_W-1:0] st_addr;
  for (genvar i = 0; i < DEPTH; i++) begin : g_st
    assign st_cand[i]                   = vld[i] && kind_q[i] == K_STORE;
    assign st_addr[i*ADDR_W +: ADDR_W]  = addr_q[i];
  end

  rob_ldhaz #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ldhaz (
    .cand      (st_cand),
    .addr_flat (st_addr),
    .ld_addr   (ld_addr),
    .hit       (ld_conflict)
  );

  // R2: occupancy never exceeds the number of entries
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3: at most one architectural write retires per cycle
  assert_one_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_we));

  // R6: a flush leaves the buffer empty on the next cycle
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_out |=> (count == '0 && vld == '0));

  // R7: an excepting instruction retires with no write
  assert_exc_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_out |-> (!rf_we && !mem_we && flush_out));
endmodule

// File: tb/rob_core_test.sv
`timescale 1ns/1ps
module rob_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [1:0]  alloc_kind = '0;
  logic [4:0]  alloc_reg = '0;
  logic [15:0] alloc_addr = '0;
  logic [2:0]  alloc_tag;
  logic        cmp_valid = 1'b0;
  logic [2:0]  cmp_tag = '0;
  logic [31:0] cmp_value = '0;
  logic        cmp_exc = 1'b0;
  logic        cmp_mispred = 1'b0;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [31:0] rf_data;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;
  logic        flush_out, exc_out;
  logic [2:0]  exc_tag;
  logic [4:0]  lk_reg = '0;
  logic        lk_busy, lk_ready;
  logic [2:0]  lk_tag;
  logic [31:0] lk_value;
  logic [15:0] ld_addr = '0;
  logic        ld_conflict;

  rob_core uut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int log_n = 0, flush_n = 0, exc_n = 0;
  int last_exc = -1;
  int log_k [64];
  int log_a [64];
  int log_d [64];
  int exp_tail = 0;

  always @(negedge clk) if (rst_n) begin
    if (rf_we && log_n < 64) begin
      log_k[log_n] = 0; log_a[log_n] = rf_idx; log_d[log_n] = rf_data; log_n++;
    end
    if (mem_we && log_n < 64) begin
      log_k[log_n] = 1; log_a[log_n] = mem_addr; log_d[log_n] = mem_data; log_n++;
    end
    if (flush_out) flush_n++;
    if (exc_out) begin exc_n++; last_exc = exc_tag; end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic alloc(input int kind, input int rg, input int ad, output int tag);
    alloc_valid = 1'b1; alloc_kind = 2'(kind); alloc_reg = 5'(rg); alloc_addr = 16'(ad);
    #0.5;
    tag = alloc_tag;
    chk("R2", "alloc_tag", tag, exp_tail);
    chk("R2", "alloc_ready", alloc_ready, 1);
    exp_tail = (exp_tail + 1) % 8;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic complete(input int tag, input int val, input bit e, input bit m);
    cmp_valid = 1'b1; cmp_tag = 3'(tag); cmp_value = val; cmp_exc = e; cmp_mispred = m;
    tick();
    cmp_valid = 1'b0; cmp_exc = 1'b0; cmp_mispred = 1'b0;
  endtask

  task automatic chk_log(input string req, input int idx, input int k, input int a, input int d);
    chk(req, "log kind", (idx < log_n) ? log_k[idx] : -1, k);
    chk(req, "log dest", (idx < log_n) ? log_a[idx] : -1, a);
    chk(req, "log data", (idx < log_n) ? log_d[idx] : -1, d);
  endtask

  task automatic t_reset();
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "rf_we", rf_we, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "flush/exc", flush_out | exc_out, 0);
    chk("R1", "lk_busy", lk_busy, 0);
    chk("R1", "ld_conflict", ld_conflict, 0);
  endtask

  task automatic t_order();
    int t[4];
    int base = log_n;
    for (int i = 0; i < 4; i++) alloc(0, i + 1, 0, t[i]);
    complete(t[3], 32'h33, 0, 0);
    complete(t[1], 32'h11, 0, 0);
    complete(t[2], 32'h22, 0, 0);
    idle(2);
    chk("R4", "no commit while head pending", log_n - base, 0);
    complete(t[0], 32'h00, 0, 0);
    idle(4);
    chk("R4", "commit count", log_n - base, 4);
    for (int i = 0; i < 4; i++) chk_log("R3", base + i, 0, i + 1, (i == 0) ? 0 : 32'h11 * i);
  endtask

  task automatic t_lookup();
    int a, b;
    int base = log_n;
    alloc(0, 5, 0, a);
    alloc(0, 5, 0, b);
    lk_reg = 5'd5; #0.5;
    chk("R5", "busy", lk_busy, 1);
    chk("R5", "newest tag", lk_tag, b);
    chk("R5", "not ready", lk_ready, 0);
    complete(a, 32'h1111, 0, 0);
    idle(2);
    chk_log("R3", base, 0, 5, 32'h1111);
    chk("R8", "still busy", lk_busy, 1);
    chk("R8", "tag kept", lk_tag, b);
    complete(b, 32'h5555, 0, 0);
    chk("R5", "ready", lk_ready, 1);
    chk("R5", "value", lk_value, 32'h5555);
    idle(2);
    chk("R5", "busy cleared", lk_busy, 0);
  endtask

  task automatic t_store();
    int s;
    int base = log_n;
    alloc(1, 0, 16'h0040, s);
    ld_addr = 16'h0040; #0.5;
    chk("R9", "match", ld_conflict, 1);
    ld_addr = 16'h0044; #0.5;
    chk("R9", "other address", ld_conflict, 0);
    complete(s, 32'hABCD, 0, 0);
    idle(2);
    chk_log("R3", base, 1, 16'h0040, 32'hABCD);
    ld_addr = 16'h0040; #0.5;
    chk("R9", "after retire", ld_conflict, 0);
  endtask

  task automatic t_full();
    int t[8];
    int base = log_n;
    for (int i = 0; i < 8; i++) alloc(0, 10 + i, 0, t[i]);
    #0.5;
    chk("R2", "full stalls", alloc_ready, 0);
    for (int i = 7; i >= 0; i--) complete(t[i], 100 + i, 0, 0);
    idle(9);
    chk("R4", "commit count", log_n - base, 8);
    for (int i = 0; i < 8; i++) chk_log("R4", base + i, 0, 10 + i, 100 + i);
    chk("R2", "ready after drain", alloc_ready, 1);
  endtask

  task automatic t_branch();
    int b, x, y;
    int base = log_n;
    int fb = flush_n;
    alloc(2, 0, 0, b);
    complete(b, 0, 0, 0);
    idle(2);
    chk("R3", "branch no write", log_n - base, 0);
    chk("R3", "branch no flush", flush_n - fb, 0);
    alloc(2, 0, 0, b);
    alloc(0, 7, 0, x);
    alloc(0, 8, 0, y);
    complete(x, 7, 0, 0);
    complete(y, 8, 0, 0);
    idle(2);
    chk("R4", "stuck behind branch", log_n - base, 0);
    complete(b, 0, 0, 1);
    chk("R6", "flush pulse", flush_n - fb, 1);
    idle(3);
    chk("R6", "younger discarded", log_n - base, 0);
    lk_reg = 5'd7; #0.5;
    chk("R10", "r7 not busy", lk_busy, 0);
    exp_tail = (b + 1) % 8;
    chk("R6", "tail after branch", alloc_tag, exp_tail);
    chk("R6", "ready", alloc_ready, 1);
  endtask

  task automatic t_exc();
    int e, f, g;
    int base = log_n;
    int eb = exc_n;
    alloc(0, 9, 0, e);
    alloc(0, 10, 0, f);
    complete(f, 10, 0, 0);
    complete(e, 9, 1, 0);
    chk("R7", "exc pulse", exc_n - eb, 1);
    chk("R7", "exc tag", last_exc, e);
    idle(3);
    chk("R7", "no writes", log_n - base, 0);
    exp_tail = (e + 1) % 8;
    chk("R7", "tail after exc", alloc_tag, exp_tail);
    alloc(0, 11, 0, g);
    complete(g, 32'h77, 0, 0);
    idle(2);
    chk_log("R7", base, 0, 11, 32'h77);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_lookup();
    t_store();
    t_full();
    t_branch();
    t_exc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule